// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer for software supervision. It sits on a simple 32-bit register bus with three registers: a control/status word, a live count and a timeout limit. Once enabled, the count advances on each cycle in which the tick-enable input is high. When the count reaches the limit, the block raises a reset request for one cycle and stops counting. Software keeps the system alive by writing a refresh key to the count register, which restarts the count from zero.

Configuration is guarded. The control and timeout registers take writes only inside a short window. That window opens when software writes an unlock key to the count register. Keys are either one 32-bit word or two 16-bit halves in a fixed order, as the command-width bit in the control word selects. Software can seal the configuration by clearing the update-permit bit, and the block then ignores every later unlock until reset. Two sideband inputs report low-power wait and stop states. The count freezes in each state unless its own run bit is set.

Top module: `keywd_top`

## Requirements
- R1: After reset the control word reads 0x0000_0020 (update permit set, everything else clear), the count reads 0, the timeout reads TOUT_RESET and resetReq is low. The control word is at offset 0x0, the count at 0x4 and the timeout at 0x8.
- R2: A write to the control or timeout register while the block is locked has no effect on the value read back.
- R3: With control bit 13 clear, writing 0xC520 and then 0xD928 to the count register unlocks the block, and control bit 11 reads 1 while it is unlocked. A half written out of order, or a write matching no key, discards any partial sequence.
- R4: With control bit 13 set, a single write of 0xD928C520 unlocks the block. The 16-bit halves alone do not unlock it.
- R5: A refresh sets the count to 0 and rearms the block. In 32-bit mode the refresh is 0xB480A602. In 16-bit mode it is 0xA602 followed by 0xB480. Any other value written to the count register leaves the count unchanged.
- R6: The unlock window closes WIN_CYC cycles after it opens, or as soon as both the control and timeout registers have been written. Control bit 10 reads 1 after a write is accepted in the window, and a new unlock clears it. An unlock while the window is already open is ignored.
- R7: While control bit 7 is set, the count rises by exactly one on each cycle in which tickEn is high.
- R8: While waitMode is high the count freezes unless control bit 1 is set. While stopMode is high it freezes unless control bit 0 is set.
- R9: When the block is enabled and the count has reached the timeout, resetReq goes high for exactly one cycle and the count then holds.
- R10: Once a reconfiguration clears control bit 5, the block ignores every later unlock until reset.
- R11: Control bits 9:8 (clock select) are stored and read back, and they have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| tickEn | input | 1 | Count tick enable |
| waitMode | input | 1 | Low-power wait state indicator |
| stopMode | input | 1 | Low-power stop state indicator |
| resetReq | output | 1 | One-cycle reset request on expiry |

## Verification
The key decoder is tested with halves written in reverse order, with a foreign word between the halves, and with 16-bit halves sent while 32-bit mode is on. A decoder that kept a stale partial state, or that accepted the wrong key width, would open the window when it should not. The window is held open past its length, and a timeout write is then attempted. This catches a window that never expires or a write gate that ignores the lock. The expiry test counts the exact number of cycles from refresh to resetReq and checks that the pulse lasts one cycle; an off-by-one in the compare or a sticky request would show there. The sealing test clears the permit bit and then sends a valid unlock, which a design that only checked the key would wrongly accept.

// File: rtl/keywd_pkg.sv
package keywd_pkg;
  localparam int unsigned BUS_W = 32;

  localparam int unsigned OFS_CTL = 0;
  localparam int unsigned OFS_CNT = 4;
  localparam int unsigned OFS_TOV = 8;

  localparam logic [31:0] KEY_UNLOCK32  = 32'hD928_C520;
  localparam logic [31:0] KEY_REFRESH32 = 32'hB480_A602;
  localparam logic [15:0] UNLOCK_LO  = KEY_UNLOCK32[15:0];
  localparam logic [15:0] UNLOCK_HI  = KEY_UNLOCK32[31:16];
  localparam logic [15:0] REFRESH_LO = KEY_REFRESH32[15:0];
  localparam logic [15:0] REFRESH_HI = KEY_REFRESH32[31:16];

  localparam int unsigned B_CMD32   = 13;
  localparam int unsigned B_OPEN    = 11;
  localparam int unsigned B_DONE    = 10;
  localparam int unsigned B_CSEL_HI = 9;
  localparam int unsigned B_CSEL_LO = 8;
  localparam int unsigned B_EN      = 7;
  localparam int unsigned B_ALLOW   = 5;
  localparam int unsigned B_WAITRUN = 1;
  localparam int unsigned B_STOPRUN = 0;

  typedef enum logic [1:0] {
    PART_NONE,
    PART_UNLOCK,
    PART_REFRESH
  } keyPart_t;

  typedef struct packed {
    logic       cmd32;
    logic [1:0] clkSel;
    logic       en;
    logic       allow;
    logic       waitRun;
    logic       stopRun;
  } wdCfg_t;

  typedef struct packed {
    logic clearCnt;
    logic armed;
    logic countEn;
  } dpStrobe_t;
endpackage

// File: rtl/keywd_ctrl.sv
module keywd_ctrl
  import keywd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned WIN_CYC    = 255,
  parameter int unsigned TOUT_RESET = 60000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]   busWdata,
  input  logic               tickEn,
  input  logic               waitMode,
  input  logic               stopMode,
  input  logic [CNT_W-1:0]   cntQ,
  output dpStrobe_t          strobe,
  output logic [CNT_W-1:0]   timeoutQ,
  output logic [BUS_W-1:0]   busRdata,
  output logic               unlockedQ,
  output logic               enQ,
  output logic               allowQ
);
  localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_TOV = ADDR_W'(OFS_TOV);

  wdCfg_t     cfgQ;
  keyPart_t   partQ, partNext;
  logic [WIN_W-1:0] winCntQ;
  logic       ctlDoneQ, tovDoneQ, appliedQ;
  logic       wrCnt, wrCtl, wrTov;
  logic       unlockHit, refreshHit, unlockGo, winClose;

  // key decode on writes to the count register
  always_comb begin
    wrCnt = busWr && (busAddr == A_CNT);
    wrCtl = busWr && (busAddr == A_CTL) && unlockedQ;
    wrTov = busWr && (busAddr == A_TOV) && unlockedQ;
    unlockHit  = 1'b0;
    refreshHit = 1'b0;
    partNext   = partQ;
    if (wrCnt) begin
      partNext = PART_NONE;
      if (cfgQ.cmd32) begin
        unlockHit  = (busWdata == KEY_UNLOCK32);
        refreshHit = (busWdata == KEY_REFRESH32);
      end else begin
        unlockHit  = (partQ == PART_UNLOCK)  && (busWdata == {16'h0, UNLOCK_HI});
        refreshHit = (partQ == PART_REFRESH) && (busWdata == {16'h0, REFRESH_HI});
        if (busWdata == {16'h0, UNLOCK_LO})       partNext = PART_UNLOCK;
        else if (busWdata == {16'h0, REFRESH_LO}) partNext = PART_REFRESH;
      end
    end
  end

  assign unlockGo = unlockHit && cfgQ.allow && !unlockedQ;
  assign winClose = (winCntQ == WIN_W'(WIN_CYC - 1)) ||
                    ((ctlDoneQ || wrCtl) && (tovDoneQ || wrTov));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) partQ <= PART_NONE;
    else        partQ <= partNext;
  end

  // reconfiguration window and guarded registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlockedQ <= 1'b0;
      winCntQ   <= '0;
      ctlDoneQ  <= 1'b0;
      tovDoneQ  <= 1'b0;
      appliedQ  <= 1'b0;
      cfgQ      <= '{cmd32: 1'b0, clkSel: 2'b00, en: 1'b0, allow: 1'b1,
                     waitRun: 1'b0, stopRun: 1'b0};
      timeoutQ  <= CNT_W'(TOUT_RESET);
    end else if (unlockGo) begin
      unlockedQ <= 1'b1;
      winCntQ   <= '0;
      ctlDoneQ  <= 1'b0;
      tovDoneQ  <= 1'b0;
      appliedQ  <= 1'b0;
    end else if (unlockedQ) begin
      if (wrCtl) begin
        cfgQ.cmd32   <= busWdata[B_CMD32];
        cfgQ.clkSel  <= busWdata[B_CSEL_HI:B_CSEL_LO];
        cfgQ.en      <= busWdata[B_EN];
        cfgQ.allow   <= busWdata[B_ALLOW];
        cfgQ.waitRun <= busWdata[B_WAITRUN];
        cfgQ.stopRun <= busWdata[B_STOPRUN];
        ctlDoneQ     <= 1'b1;
        appliedQ     <= 1'b1;
      end
      if (wrTov) begin
        timeoutQ <= busWdata[CNT_W-1:0];
        tovDoneQ <= 1'b1;
        appliedQ <= 1'b1;
      end
      if (winClose) unlockedQ <= 1'b0;
      else          winCntQ   <= winCntQ + 1'b1;
    end
  end

  always_comb begin
    strobe.clearCnt = refreshHit;
    strobe.armed    = cfgQ.en;
    strobe.countEn  = cfgQ.en && tickEn &&
                      (!waitMode || cfgQ.waitRun) &&
                      (!stopMode || cfgQ.stopRun);
  end

  // register read mux
  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_CTL: begin
        busRdata[B_CMD32]             = cfgQ.cmd32;
        busRdata[B_OPEN]              = unlockedQ;
        busRdata[B_DONE]              = appliedQ;
        busRdata[B_CSEL_HI:B_CSEL_LO] = cfgQ.clkSel;
        busRdata[B_EN]                = cfgQ.en;
        busRdata[B_ALLOW]             = cfgQ.allow;
        busRdata[B_WAITRUN]           = cfgQ.waitRun;
        busRdata[B_STOPRUN]           = cfgQ.stopRun;
      end
      A_CNT:   busRdata = BUS_W'(cntQ);
      A_TOV:   busRdata = BUS_W'(timeoutQ);
      default: busRdata = '0;
    endcase
  end

  assign enQ    = cfgQ.en;
  assign allowQ = cfgQ.allow;
endmodule

// File: rtl/keywd_dp.sv
module keywd_dp
  import keywd_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] timeoutQ,
  output logic [CNT_W-1:0] cntQ,
  output logic             resetReq
);
  logic expiredQ;
  logic fireNow;

  assign fireNow = strobe.armed && !expiredQ && (cntQ >= timeoutQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ     <= '0;
      expiredQ <= 1'b0;
      resetReq <= 1'b0;
    end else if (strobe.clearCnt) begin
      cntQ     <= '0;
      expiredQ <= 1'b0;
      resetReq <= 1'b0;
    end else if (fireNow) begin
      expiredQ <= 1'b1;
      resetReq <= 1'b1;
    end else begin
      resetReq <= 1'b0;
      if (strobe.countEn && !expiredQ) cntQ <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/keywd_top.sv
module keywd_top
  import keywd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned WIN_CYC    = 255,
  parameter int unsigned TOUT_RESET = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              tickEn,
  input  logic              waitMode,
  input  logic              stopMode,
  output logic              resetReq
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] timeoutQ;
  logic             unlockedQ, enQ, allowQ;

  keywd_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_CYC(WIN_CYC), .TOUT_RESET(TOUT_RESET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .tickEn(tickEn), .waitMode(waitMode),
    .stopMode(stopMode), .cntQ(cntQ), .strobe(strobe), .timeoutQ(timeoutQ),
    .busRdata(busRdata), .unlockedQ(unlockedQ), .enQ(enQ), .allowQ(allowQ)
  );

  keywd_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .timeoutQ(timeoutQ),
    .cntQ(cntQ), .resetReq(resetReq)
  );
endmodule

// File: rtl/keywd_checker.sv
module keywd_checker #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned WIN_CYC = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resetReq,
  input logic             unlockedQ,
  input logic             enQ,
  input logic             allowQ,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] timeoutQ
);
  localparam int unsigned RUN_W = $clog2(WIN_CYC + 2);
  logic [RUN_W-1:0] winRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          winRun <= '0;
    else if (!unlockedQ) winRun <= '0;
    else if (winRun <= RUN_W'(WIN_CYC)) winRun <= winRun + 1'b1;
  end

  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    winRun <= RUN_W'(WIN_CYC));

  a_r2_timeout_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlockedQ |=> $stable(timeoutQ));

  a_r10_sealed: assert property (@(posedge clk) disable iff (!rst_n)
    (!allowQ && !unlockedQ) |=> !unlockedQ);

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |=> !resetReq);

  a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetReq) |-> $past(enQ));

  a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cntQ != '0) |-> (cntQ == $past(cntQ) || cntQ == $past(cntQ) + 1'b1));
endmodule

bind keywd_top keywd_checker #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .resetReq(resetReq), .unlockedQ(unlockedQ),
  .enQ(enQ), .allowQ(allowQ), .cntQ(cntQ), .timeoutQ(timeoutQ)
);

// File: tb/tb_keywd_top.sv
`timescale 1ns/1ps
module tb_keywd_top;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned WIN    = 255;
  localparam int unsigned TRST   = 60000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic tickEn = 1'b0, waitMode = 1'b0, stopMode = 1'b0;
  logic resetReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  event        sampleEv;

  always #4 clk = ~clk;

  keywd_top #(.ADDR_W(ADDR_W), .WIN_CYC(WIN), .TOUT_RESET(TRST)) dut (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn),
    .waitMode(waitMode), .stopMode(stopMode), .resetReq(resetReq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares with the bus
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdata === e, t, busRdata, e);
      end
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic expectRead(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busAddr = a;
    #1;
    expQ.push_back(e);
    tagQ.push_back(t);
    ->sampleEv;
    #1;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog timeout", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(resetReq === 1'b0, "R1 resetReq", 32'(resetReq), 32'h0);
    expectRead(4'h0, 32'h0000_0020, "R1 ctrl");
    expectRead(4'h4, 32'h0, "R1 count");
    expectRead(4'h8, TRST, "R1 timeout");

    // R2 locked writes ignored
    busWrite(4'h0, 32'hFFFF_FFFF);
    busWrite(4'h8, 32'd5);
    expectRead(4'h0, 32'h0000_0020, "R2 ctrl locked");
    expectRead(4'h8, TRST, "R2 timeout locked");

    // R3 out-of-order and broken 16-bit sequences
    busWrite(4'h4, 32'h0000_D928);
    busWrite(4'h4, 32'h0000_C520);
    busWrite(4'h4, 32'h0000_1111);
    busWrite(4'h4, 32'h0000_D928);
    expectRead(4'h0, 32'h0000_0020, "R3 broken sequence stays locked");
    busWrite(4'h4, 32'h0000_C520);
    busWrite(4'h4, 32'h0000_D928);
    expectRead(4'h0, 32'h0000_0820, "R3 16-bit unlock");

    // R6 applied flag, R11 clock select, close after both writes
    busWrite(4'h8, 32'd10);
    expectRead(4'h0, 32'h0000_0C20, "R6 applied flag");
    busWrite(4'h0, 32'h0000_21A0);
    expectRead(4'h0, 32'h0000_25A0, "R6 R11 closed after both writes");
    expectRead(4'h8, 32'd10, "R6 timeout written");

    // R4 halves do not unlock in 32-bit mode
    busWrite(4'h4, 32'h0000_C520);
    busWrite(4'h4, 32'h0000_D928);
    expectRead(4'h0, 32'h0000_25A0, "R4 halves ignored in 32-bit mode");

    // R5 refresh, R7 counting
    busWrite(4'h4, 32'hB480_A602);
    ticks(4);
    expectRead(4'h4, 32'd4, "R7 four ticks");

    // R8 low-power freeze
    waitMode = 1'b1;
    ticks(3);
    expectRead(4'h4, 32'd4, "R8 wait freeze");
    waitMode = 1'b0;
    stopMode = 1'b1;
    ticks(3);
    expectRead(4'h4, 32'd4, "R8 stop freeze");
    stopMode = 1'b0;

    // R5 foreign values ignored
    busWrite(4'h4, 32'h1234_5678);
    busWrite(4'h4, 32'h0000_A602);
    expectRead(4'h4, 32'd4, "R5 foreign write ignored");
    busWrite(4'h4, 32'hB480_A602);
    expectRead(4'h4, 32'd0, "R5 32-bit refresh");

    // R9 expiry timing: timeout 10 -> pulse after 11 ticking edges
    @(negedge clk);
    tickEn = 1'b1;
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk);
      #2;
      if (resetReq === 1'b1) begin
        n = i;
        break;
      end
    end
    check(n == 11, "R9 expiry cycle", 32'(n), 32'd11);
    @(posedge clk);
    #2;
    check(resetReq === 1'b0, "R9 one-cycle pulse", 32'(resetReq), 32'h0);
    @(negedge clk);
    tickEn = 1'b0;
    expectRead(4'h4, 32'd10, "R9 count holds");

    // R6 window expiry
    busWrite(4'h4, 32'hD928_C520);
    expectRead(4'h0, 32'h0000_29A0, "R6 reopened, applied cleared");
    repeat (WIN + 5) @(negedge clk);
    expectRead(4'h0, 32'h0000_21A0, "R6 window expired");
    busWrite(4'h8, 32'd99);
    expectRead(4'h8, 32'd10, "R6 R2 write after expiry");

    // R10 seal, then R5 16-bit refresh
    busWrite(4'h4, 32'hD928_C520);
    busWrite(4'h0, 32'h0000_0080);
    busWrite(4'h8, 32'd10);
    expectRead(4'h0, 32'h0000_0480, "R10 sealed config");
    busWrite(4'h4, 32'h0000_A602);
    busWrite(4'h4, 32'h0000_B480);
    expectRead(4'h4, 32'd0, "R5 16-bit refresh");
    busWrite(4'h4, 32'h0000_C520);
    busWrite(4'h4, 32'h0000_D928);
    expectRead(4'h0, 32'h0000_0480, "R10 unlock ignored");
    busWrite(4'h0, 32'h0000_0020);
    expectRead(4'h0, 32'h0000_0480, "R10 ctrl unchanged");

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule